// File: doc/BRIEF.md
# Black Level Servo

This block closes a digital loop that removes the DC offset of one video colour channel. Once per line, after horizontal sync goes inactive, it waits a programmable number of pixel clocks and then sums a short window of ADC samples taken on the black porch. It divides that sum by a shift to get the line's black level and compares it with the black target. The error is collected over a power-of-two number of lines, and the averaged error moves a 10-bit offset DAC code. The analog side subtracts that code from the signal before the ADC.

The update is skipped for any line whose trailing sync edge arrives while the clock recovery loop is coasting, unless software allows coasting updates. While the servo runs, a signed 8-bit user offset is added to every pixel in the digital domain, and the result is clamped to the 8-bit range. When the servo is switched off, the DAC code comes straight from two user fields and the pixels pass through unchanged. A half-swing option tells the loop that one DAC step is worth 1/8 of an ADC code instead of 1/4, and the loop doubles its step to match.

Top module: `blk_lvl_servo`

## Requirements
- R1: After reset, `dac_code` is 512 (mid-scale) and `pix_out` is 0.
- R2: Let edge 0 be the first rising clock edge at which `hsync` is low after being high. With delay field D, the samples averaged are those present at edges D+1 through D+N. D=0 is legal.
- R3: The number of samples is N = 2^(`cfg_avg_sel`+1), that is 2, 4, 8 or 16. The line black level is the sample sum shifted right by `cfg_avg_sel`+1, rounded down.
- R4: The line error (black level minus target 0) is collected over 2^`cfg_line_sel` lines. The DAC code does not change before the last of those lines. The mean error is the collected sum shifted right arithmetically by `cfg_line_sel`.
- R5: A measurement run starts only if `pll_coast` is low or `cfg_coast_ok` is high at edge 0. Otherwise that line leaves the DAC code unchanged.
- R6: The DAC code grows by the mean error times 4 (`cfg_half_range`=0) or times 8 (`cfg_half_range`=1). The result saturates at 0 and 1023.
- R7: While `cfg_servo_off` is high, `dac_code` equals {`cfg_man_hi`, `cfg_man_lo`} in the same cycle, and sync activity has no effect. On re-enable, the servo resumes from that manual code.
- R8: With the servo on, `pix_out` is `adc_data` plus the two's-complement `cfg_user_off`, clamped to 0..255, one clock later. With the servo off, `pix_out` is `adc_data` one clock later.
- R9: A rising sync edge, or sync held high, starts no run. A new trailing edge that arrives while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync | input | 1 | Horizontal sync, high during the pulse |
| pll_coast | input | 1 | Clock recovery loop is coasting |
| adc_data | input | 8 | ADC sample for this channel |
| cfg_servo_off | input | 1 | 1 = servo off, manual DAC code |
| cfg_coast_ok | input | 1 | 1 = allow runs while coasting |
| cfg_half_range | input | 1 | 1 = DAC swing halved (step 1/8 ADC code) |
| cfg_delay | input | 16 | Pixel delay from trailing sync edge |
| cfg_avg_sel | input | 2 | Samples per line, 2^(n+1) |
| cfg_line_sel | input | 3 | Lines per update, 2^n |
| cfg_user_off | input | 8 | Signed digital offset applied with servo on |
| cfg_man_hi | input | 8 | Manual DAC code, upper 8 bits |
| cfg_man_lo | input | 2 | Manual DAC code, lower 2 bits |
| dac_code | output | 10 | Offset DAC code |
| pix_out | output | 8 | Offset-corrected pixel |

## Verification
A misplaced sample window pulls porch-adjacent values into the average. This shows as a grossly wrong DAC code within the first update period, a few lines after the trailing edge. A wrong line or sample count, a missing coast gate, or a lost saturation shows at `dac_code` at the first update boundary as a code different from mid-scale plus four or eight times the offset error. The bench models a fixed analog offset as a DAC-dependent ADC value, so a loop with the wrong sign or gain never settles on the single code it computes. Pixel path errors are visible on `pix_out` one clock after the sample.

// File: rtl/bls_pkg.sv
// Shared types for the black level servo.
// Assumes: nothing beyond IEEE 1800-2017.
package bls_pkg;
    // Per-line measurement sequencer states.
    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_WAIT   = 2'd1,
        SQ_SAMPLE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/bls_line_seq.sv
// Line sequencer: finds the trailing sync edge, waits the programmed
// pixel delay, then raises a sample window of 2^(sel+1) pixels.
// Assumes: hsync is synchronous to clk; one run per line at most.
module bls_line_seq
    import bls_pkg::*;
#(
    parameter int DLY_W     = 16,
    parameter int AVG_SEL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hsync,
    input  logic                 pll_coast,
    input  logic                 servo_en,
    input  logic                 coast_ok,
    input  logic [DLY_W-1:0]     cfg_delay,
    input  logic [AVG_SEL_W-1:0] cfg_avg_sel,
    output logic                 smp_en,
    output logic                 smp_first,
    output logic                 smp_last
);
    localparam int MAX_N  = 2 << ((1 << AVG_SEL_W) - 1);
    localparam int SCNT_W = $clog2(MAX_N);

    seq_state_e          state;
    logic                hs_q;
    logic                trail;
    logic                trig;
    logic [DLY_W-1:0]    dcnt;
    logic [SCNT_W-1:0]   scnt;
    logic [SCNT_W-1:0]   n_last;

    // Trailing edge of sync and run-start qualification.
    always_comb begin
        trail  = hs_q && !hsync;
        trig   = trail && servo_en && (!pll_coast || coast_ok) && (state == SQ_IDLE);
        n_last = SCNT_W'((32'd2 << cfg_avg_sel) - 32'd1);
    end

    // Window strobes for the averager.
    always_comb begin
        smp_en    = (state == SQ_SAMPLE);
        smp_first = (state == SQ_SAMPLE) && (scnt == '0);
        smp_last  = (state == SQ_SAMPLE) && (scnt == n_last);
    end

    // Sync history register.
    always_ff @(posedge clk) begin
        if (!rst_n) hs_q <= 1'b0;
        else        hs_q <= hsync;
    end

    // Delay and window state machine.
    always_ff @(posedge clk) begin
        if (!rst_n || !servo_en) begin
            state <= SQ_IDLE;
            dcnt  <= '0;
            scnt  <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (trig) begin
                        scnt <= '0;
                        if (cfg_delay == '0) begin
                            state <= SQ_SAMPLE;
                        end else begin
                            state <= SQ_WAIT;
                            dcnt  <= cfg_delay - 1'b1;
                        end
                    end
                end
                SQ_WAIT: begin
                    if (dcnt == '0) state <= SQ_SAMPLE;
                    else            dcnt  <= dcnt - 1'b1;
                end
                SQ_SAMPLE: begin
                    if (scnt == n_last) state <= SQ_IDLE;
                    else                scnt  <= scnt + 1'b1;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // R2: the window is only entered straight from idle when the delay is zero.
    a_r2_zero_delay_only: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_SAMPLE && $past(state) == SQ_IDLE) |-> ($past(cfg_delay) == '0));

    // R5: a run never starts on a coasting line unless allowed.
    a_r5_coast_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SQ_IDLE && $past(state) == SQ_IDLE) |-> ($past(!pll_coast) || $past(coast_ok)));

    // R9: a run starts only after sync was seen falling.
    a_r9_falling_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SQ_IDLE && $past(state) == SQ_IDLE) |-> ($past(hs_q) && !$past(hsync)));
endmodule

// File: rtl/bls_black_avg.sv
// Black averager: sums the samples inside the window and divides by
// the window length with a right shift, one result per window.
// Assumes: window strobes come from bls_line_seq with the same select.
module bls_black_avg #(
    parameter int ADC_W     = 8,
    parameter int AVG_SEL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADC_W-1:0]     adc_data,
    input  logic [AVG_SEL_W-1:0] cfg_avg_sel,
    input  logic                 smp_en,
    input  logic                 smp_first,
    input  logic                 smp_last,
    output logic                 avg_valid,
    output logic [ADC_W-1:0]     avg_val
);
    localparam int MAX_N = 2 << ((1 << AVG_SEL_W) - 1);
    localparam int SUM_W = ADC_W + $clog2(MAX_N) + 1;

    logic [SUM_W-1:0]     sum_q;
    logic [SUM_W-1:0]     sum_nxt;
    logic [AVG_SEL_W:0]   shamt;

    // Running sum including the current sample.
    always_comb begin
        sum_nxt = (smp_first ? '0 : sum_q) + SUM_W'(adc_data);
        shamt   = {1'b0, cfg_avg_sel} + 1'b1;
    end

    // Sum register and one-cycle result strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q     <= '0;
            avg_valid <= 1'b0;
            avg_val   <= '0;
        end else begin
            avg_valid <= 1'b0;
            if (smp_en) begin
                sum_q <= sum_nxt;
                if (smp_last) begin
                    avg_valid <= 1'b1;
                    avg_val   <= ADC_W'(sum_nxt >> shamt);
                end
            end
        end
    end

    // R3: each window closes with exactly one result strobe.
    a_r3_result_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en && smp_last) |=> avg_valid);

    // R3: no result without a window closing the cycle before.
    a_r3_no_stray_result: assert property (@(posedge clk) disable iff (!rst_n)
        avg_valid |-> $past(smp_last));
endmodule

// File: rtl/bls_line_acc.sv
// Line accumulator and DAC stepper: collects per-line errors over
// 2^sel lines, averages them and moves the DAC code by a scaled step
// with saturation. Tracks the manual code while the servo is off.
// Assumes: avg_valid pulses at most once per line.
module bls_line_acc #(
    parameter int ADC_W     = 8,
    parameter int DAC_W     = 10,
    parameter int LN_SEL_W  = 3,
    parameter int TARGET    = 0,
    parameter int DAC_INIT  = 512
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 servo_en,
    input  logic                 half_range,
    input  logic [LN_SEL_W-1:0]  cfg_line_sel,
    input  logic [DAC_W-1:0]     man_code,
    input  logic                 avg_valid,
    input  logic [ADC_W-1:0]     avg_val,
    output logic [DAC_W-1:0]     dac_reg
);
    localparam int MAX_LINES = 1 << ((1 << LN_SEL_W) - 1);
    localparam int LCNT_W    = (MAX_LINES > 1) ? $clog2(MAX_LINES) : 1;
    localparam int ERR_W     = ADC_W + 2;
    localparam int ACC_W     = ERR_W + LCNT_W;
    localparam int STEP_W    = ERR_W + 3;
    localparam int SUM_W     = ((STEP_W > DAC_W) ? STEP_W : DAC_W) + 2;
    localparam logic signed [SUM_W-1:0] DAC_MAX_S = SUM_W'((1 << DAC_W) - 1);

    logic [LCNT_W-1:0]        lcnt;
    logic [LCNT_W-1:0]        l_last;
    logic signed [ACC_W-1:0]  acc_q;
    logic signed [ACC_W-1:0]  acc_nxt;
    logic signed [ACC_W-1:0]  acc_sh;
    logic signed [ERR_W-1:0]  err;
    logic signed [ERR_W-1:0]  mean;
    logic signed [STEP_W-1:0] step;
    logic signed [SUM_W-1:0]  dac_sum;
    logic [DAC_W-1:0]         dac_nxt;
    logic                     last_line;

    // Line error against the black target and running collection.
    always_comb begin
        err       = $signed({2'b00, avg_val}) - $signed(ERR_W'(TARGET));
        acc_nxt   = ((lcnt == '0) ? '0 : acc_q) + ACC_W'(err);
        l_last    = LCNT_W'((32'd1 << cfg_line_sel) - 32'd1);
        last_line = (lcnt == l_last);
    end

    // Mean error, step scaling by swing and saturating DAC sum.
    always_comb begin
        acc_sh  = acc_nxt >>> cfg_line_sel;
        mean    = ERR_W'(acc_sh);
        step    = half_range ? (STEP_W'(mean) <<< 3) : (STEP_W'(mean) <<< 2);
        dac_sum = $signed({{(SUM_W-DAC_W){1'b0}}, dac_reg}) + SUM_W'(step);
        if (dac_sum < 0)              dac_nxt = '0;
        else if (dac_sum > DAC_MAX_S) dac_nxt = DAC_W'(DAC_MAX_S);
        else                          dac_nxt = dac_sum[DAC_W-1:0];
    end

    // Collection, line counting and DAC code register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_reg <= DAC_W'(DAC_INIT);
            lcnt    <= '0;
            acc_q   <= '0;
        end else if (!servo_en) begin
            dac_reg <= man_code;
            lcnt    <= '0;
            acc_q   <= '0;
        end else if (avg_valid) begin
            if (last_line) begin
                dac_reg <= dac_nxt;
                lcnt    <= '0;
            end else begin
                acc_q <= acc_nxt;
                lcnt  <= lcnt + 1'b1;
            end
        end
    end

    // R6: a non-negative step never lowers the code (no wrap at the top).
    a_r6_no_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
        (servo_en && avg_valid && last_line && step >= 0) |=> (dac_reg >= $past(dac_reg)));

    // R6: a negative step never raises the code (no wrap at the bottom).
    a_r6_no_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
        (servo_en && avg_valid && last_line && step < 0) |=> (dac_reg <= $past(dac_reg)));

    // R4: the code holds on every line that is not the last of its group.
    a_r4_hold_mid_group: assert property (@(posedge clk) disable iff (!rst_n)
        (servo_en && !(avg_valid && last_line)) |=> $stable(dac_reg));

    // R7: with the servo off the register follows the manual code.
    a_r7_track_manual: assert property (@(posedge clk) disable iff (!rst_n)
        !servo_en |=> (dac_reg == $past(man_code)));
endmodule

// File: rtl/bls_pix_offset.sv
// Pixel path: adds the signed user offset with clamping while the servo
// runs, passes the sample unchanged otherwise; one register stage.
// Assumes: user offset is two's complement of the ADC width.
module bls_pix_offset #(
    parameter int ADC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              servo_en,
    input  logic [ADC_W-1:0]  adc_data,
    input  logic [ADC_W-1:0]  user_off,
    output logic [ADC_W-1:0]  pix_out
);
    localparam int PW = ADC_W + 2;
    localparam logic signed [PW-1:0] PIX_MAX = PW'((1 << ADC_W) - 1);

    logic signed [PW-1:0] psum;
    logic [ADC_W-1:0]     pclamp;

    // Signed add and clamp to the pixel range.
    always_comb begin
        psum = $signed({2'b00, adc_data}) + $signed({{2{user_off[ADC_W-1]}}, user_off});
        if (psum < 0)            pclamp = '0;
        else if (psum > PIX_MAX) pclamp = '1;
        else                     pclamp = psum[ADC_W-1:0];
    end

    // Output register with mode select.
    always_ff @(posedge clk) begin
        if (!rst_n)        pix_out <= '0;
        else if (servo_en) pix_out <= pclamp;
        else               pix_out <= adc_data;
    end

    // R8: full-scale input with a non-negative offset stays at full scale.
    a_r8_clamp_high: assert property (@(posedge clk) disable iff (!rst_n)
        $past(servo_en && adc_data == '1 && !user_off[ADC_W-1]) |-> (pix_out == '1));

    // R8: zero input with a negative offset clamps to zero.
    a_r8_clamp_low: assert property (@(posedge clk) disable iff (!rst_n)
        $past(servo_en && adc_data == '0 && user_off[ADC_W-1]) |-> (pix_out == '0));

    // R8: with the servo off the pixel is the previous sample.
    a_r8_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!servo_en) |-> (pix_out == $past(adc_data)));
endmodule

// File: rtl/blk_lvl_servo.sv
// Top of the black level servo for one colour channel: sequencer,
// averager, line accumulator and pixel offset path, plus the manual
// DAC code select.
// Assumes: all inputs synchronous to the pixel clock.
module blk_lvl_servo #(
    parameter int ADC_W     = 8,
    parameter int DAC_W     = 10,
    parameter int DLY_W     = 16,
    parameter int AVG_SEL_W = 2,
    parameter int LN_SEL_W  = 3,
    parameter int TARGET    = 0,
    parameter int DAC_INIT  = 512
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hsync,
    input  logic                   pll_coast,
    input  logic [ADC_W-1:0]       adc_data,
    input  logic                   cfg_servo_off,
    input  logic                   cfg_coast_ok,
    input  logic                   cfg_half_range,
    input  logic [DLY_W-1:0]       cfg_delay,
    input  logic [AVG_SEL_W-1:0]   cfg_avg_sel,
    input  logic [LN_SEL_W-1:0]    cfg_line_sel,
    input  logic [ADC_W-1:0]       cfg_user_off,
    input  logic [ADC_W-1:0]       cfg_man_hi,
    input  logic [DAC_W-ADC_W-1:0] cfg_man_lo,
    output logic [DAC_W-1:0]       dac_code,
    output logic [ADC_W-1:0]       pix_out
);
    logic             servo_en;
    logic             smp_en;
    logic             smp_first;
    logic             smp_last;
    logic             avg_valid;
    logic [ADC_W-1:0] avg_val;
    logic [DAC_W-1:0] man_code;
    logic [DAC_W-1:0] dac_reg;

    // Mode decode and manual code assembly.
    always_comb begin
        servo_en = !cfg_servo_off;
        man_code = {cfg_man_hi, cfg_man_lo};
        dac_code = servo_en ? dac_reg : man_code;
    end

    bls_line_seq #(.DLY_W(DLY_W), .AVG_SEL_W(AVG_SEL_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .pll_coast(pll_coast),
        .servo_en(servo_en), .coast_ok(cfg_coast_ok), .cfg_delay(cfg_delay),
        .cfg_avg_sel(cfg_avg_sel), .smp_en(smp_en), .smp_first(smp_first),
        .smp_last(smp_last)
    );

    bls_black_avg #(.ADC_W(ADC_W), .AVG_SEL_W(AVG_SEL_W)) avg_i (
        .clk(clk), .rst_n(rst_n), .adc_data(adc_data), .cfg_avg_sel(cfg_avg_sel),
        .smp_en(smp_en), .smp_first(smp_first), .smp_last(smp_last),
        .avg_valid(avg_valid), .avg_val(avg_val)
    );

    bls_line_acc #(.ADC_W(ADC_W), .DAC_W(DAC_W), .LN_SEL_W(LN_SEL_W),
                   .TARGET(TARGET), .DAC_INIT(DAC_INIT)) acc_i (
        .clk(clk), .rst_n(rst_n), .servo_en(servo_en), .half_range(cfg_half_range),
        .cfg_line_sel(cfg_line_sel), .man_code(man_code), .avg_valid(avg_valid),
        .avg_val(avg_val), .dac_reg(dac_reg)
    );

    bls_pix_offset #(.ADC_W(ADC_W)) pix_i (
        .clk(clk), .rst_n(rst_n), .servo_en(servo_en), .adc_data(adc_data),
        .user_off(cfg_user_off), .pix_out(pix_out)
    );

    // R7: manual mode shows the user code in the same cycle.
    a_r7_manual_out: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_servo_off |-> (dac_code == {cfg_man_hi, cfg_man_lo}));
endmodule

// File: tb/blk_lvl_servo_tb_top.sv
// Directed bench: a fixed analog offset is modelled as an ADC value that
// falls as the DAC code rises; each task drives lines and checks ports.
module blk_lvl_servo_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HS_HIGH    = 8;
    localparam int HS_LOW     = 56;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync = 1'b0;
    logic       pll_coast = 1'b0;
    logic [7:0] adc_data;
    logic       cfg_servo_off = 1'b0;
    logic       cfg_coast_ok = 1'b0;
    logic       cfg_half_range = 1'b0;
    logic [15:0] cfg_delay = 16'd4;
    logic [1:0] cfg_avg_sel = 2'd1;
    logic [2:0] cfg_line_sel = 3'd0;
    logic [7:0] cfg_user_off = 8'd0;
    logic [7:0] cfg_man_hi = 8'd0;
    logic [1:0] cfg_man_lo = 2'd0;
    logic [9:0] dac_code;
    logic [7:0] pix_out;

    logic       use_model = 1'b0;
    logic [7:0] adc_force = 8'd0;
    int         off8 = 0;
    int         win_lo = 0;
    int         win_hi = 100000;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Offset model: level in 1/8 ADC codes; DAC mid-scale means no correction.
    function automatic logic [7:0] model_adc(int o8, int dac, bit half);
        int lvl;
        lvl = o8 + (512 - dac) * (half ? 1 : 2);
        if (lvl < 0) return 8'd0;
        lvl = lvl / 8;
        if (lvl > 255) return 8'd255;
        return lvl[7:0];
    endfunction

    assign adc_data = use_model ? model_adc(off8, int'(dac_code), cfg_half_range) : adc_force;

    blk_lvl_servo dut_i (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .pll_coast(pll_coast),
        .adc_data(adc_data), .cfg_servo_off(cfg_servo_off), .cfg_coast_ok(cfg_coast_ok),
        .cfg_half_range(cfg_half_range), .cfg_delay(cfg_delay), .cfg_avg_sel(cfg_avg_sel),
        .cfg_line_sel(cfg_line_sel), .cfg_user_off(cfg_user_off), .cfg_man_hi(cfg_man_hi),
        .cfg_man_lo(cfg_man_lo), .dac_code(dac_code), .pix_out(pix_out)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reset with default configuration.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; hsync = 1'b0; pll_coast = 1'b0; use_model = 1'b0;
        cfg_servo_off = 1'b0; cfg_coast_ok = 1'b0; cfg_half_range = 1'b0;
        cfg_delay = 16'd4; cfg_avg_sel = 2'd1; cfg_line_sel = 3'd0;
        cfg_user_off = 8'd0; win_lo = 0; win_hi = 100000; adc_force = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One line: sync high, then low; model used only inside [win_lo, win_hi].
    task automatic run_lines(int n);
        for (int l = 0; l < n; l++) begin
            for (int h = 0; h < HS_HIGH; h++) begin
                @(negedge clk); hsync = 1'b1; use_model = 1'b0; adc_force = 8'd200;
            end
            for (int k = 0; k < HS_LOW; k++) begin
                @(negedge clk); hsync = 1'b0;
                use_model = (k >= win_lo && k <= win_hi);
                adc_force = 8'd200;
            end
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 dac after reset", int'(dac_code), 512);
        check("R1 pix after reset", int'(pix_out), 0);
    endtask

    task automatic t_pixel();
        do_reset();
        use_model = 1'b0;
        adc_force = 8'd100; cfg_user_off = 8'd20; @(negedge clk);
        check("R8 add offset", int'(pix_out), 120);
        adc_force = 8'd50; cfg_user_off = 8'hEC; @(negedge clk);
        check("R8 subtract offset", int'(pix_out), 30);
        adc_force = 8'd10; cfg_user_off = 8'hE2; @(negedge clk);
        check("R8 clamp low", int'(pix_out), 0);
        adc_force = 8'd250; cfg_user_off = 8'd20; @(negedge clk);
        check("R8 clamp high", int'(pix_out), 255);
        cfg_servo_off = 1'b1; adc_force = 8'd100; @(negedge clk);
        check("R8 bypass when off", int'(pix_out), 100);
    endtask

    task automatic t_converge_full();
        do_reset();
        off8 = 299;
        run_lines(6);
        check("R3 R6 full swing settle", int'(dac_code), 512 + 4 * 37);
    endtask

    task automatic t_converge_half();
        do_reset();
        off8 = 299; cfg_half_range = 1'b1; cfg_avg_sel = 2'd3;
        run_lines(6);
        check("R6 half swing settle", int'(dac_code), 512 + 8 * 37);
    endtask

    task automatic t_window();
        do_reset();
        off8 = 299; cfg_delay = 16'd10; cfg_avg_sel = 2'd1; win_lo = 11; win_hi = 14;
        run_lines(4);
        check("R2 delay 10 window", int'(dac_code), 660);
        do_reset();
        off8 = 299; cfg_delay = 16'd0; cfg_avg_sel = 2'd0; win_lo = 1; win_hi = 2;
        run_lines(4);
        check("R2 zero delay window", int'(dac_code), 660);
    endtask

    task automatic t_lines();
        do_reset();
        off8 = 299; cfg_line_sel = 3'd2;
        run_lines(3);
        check("R4 hold before group end", int'(dac_code), 512);
        run_lines(1);
        check("R4 update at group end", int'(dac_code), 660);
    endtask

    task automatic t_coast();
        do_reset();
        off8 = 299; pll_coast = 1'b1;
        run_lines(3);
        check("R5 no run while coasting", int'(dac_code), 512);
        cfg_coast_ok = 1'b1;
        run_lines(3);
        check("R5 run when coasting allowed", int'(dac_code), 660);
    endtask

    task automatic t_saturate();
        do_reset();
        off8 = 3000;
        run_lines(3);
        check("R6 saturate at top", int'(dac_code), 1023);
    endtask

    task automatic t_manual();
        do_reset();
        off8 = 299; cfg_servo_off = 1'b1; cfg_man_hi = 8'hA5; cfg_man_lo = 2'd2;
        #1;
        check("R7 manual code same cycle", int'(dac_code), 662);
        run_lines(2);
        check("R7 sync ignored in manual", int'(dac_code), 662);
        cfg_servo_off = 1'b0;
        @(negedge clk);
        check("R7 bumpless re-enable", int'(dac_code), 662);
        run_lines(2);
        check("R7 servo holds settled code", int'(dac_code), 662);
    endtask

    task automatic t_edges();
        do_reset();
        off8 = 299; use_model = 1'b1;
        repeat (40) begin @(negedge clk); hsync = 1'b1; end
        check("R9 rising edge and high sync ignored", int'(dac_code), 512);
        repeat (40) begin @(negedge clk); hsync = 1'b0; end
        check("R9 trailing edge starts run", int'(dac_code), 660);
        do_reset();
        off8 = 299; use_model = 1'b1; cfg_delay = 16'd20; cfg_avg_sel = 2'd0;
        @(negedge clk); hsync = 1'b1;
        @(negedge clk); hsync = 1'b0;
        repeat (3) @(negedge clk);
        off8 = 3000; hsync = 1'b1;
        @(negedge clk); hsync = 1'b0;
        repeat (12) @(negedge clk);
        off8 = 299;
        repeat (30) @(negedge clk);
        check("R9 second edge during run ignored", int'(dac_code), 660);
    endtask

    initial begin
        t_reset();
        t_pixel();
        t_converge_full();
        t_converge_half();
        t_window();
        t_lines();
        t_coast();
        t_saturate();
        t_manual();
        t_edges();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule